// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit effective offset into a 20-bit physical memory address. It keeps four segment registers (code, data, stack, extra), loaded through a small write port, and picks one of them from the class of the access: instruction fetch, stack access, operand reference, string source or string destination. An optional segment override can steer operand and string-source accesses to any of the four registers.

For operand references the offset is composed from up to three parts: a base register value, an index register value and an instruction displacement. Five memory addressing modes choose which parts take part. The offset sum wraps at 16 bits. The shifted segment plus offset wraps at 20 bits. The result is registered, so an address and its valid strobe appear one clock after a request. Instruction decode, the general register file and the bus cycle that uses the address all sit outside this block. The caller supplies the register values on the input ports.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `addr_vld` and `phys_addr` are cleared to 0 and all four segment registers are cleared to 0. After reset, a fetch with segment 0 yields `phys_addr` equal to the offset alone.
- R2: A request (`req`=1) sampled at a rising edge yields `addr_vld`=1 and the new `phys_addr` after that edge. Without a request, `addr_vld` is 0 after the edge and `phys_addr` keeps its value.
- R3: `phys_addr` = (segment × 16 + offset) mod 2^20. The effective offset itself is taken mod 2^16 before the addition.
- R4: Access class 0 (fetch) uses the code segment (index 0) with `ip_val` as the offset. The override inputs are ignored.
- R5: Access class 1 (stack) uses the stack segment (index 2). The offset is `bp_val` when `use_bp`=1 and `sp_val` otherwise. The override inputs are ignored.
- R6: Access class 2 (operand) uses the data segment (index 1) by default. With `ovr_en`=1 it uses the segment indexed by `ovr_sel` (0 code, 1 data, 2 stack, 3 extra).
- R7: For an operand with `use_bp`=1, `ovr_en`=0 and mode 1, 2 or 4 (the modes that have a base register), the stack segment replaces the data segment.
- R8: Access class 3 (string source) uses `si_val` with the data segment, and honours the override. Class 4 (string destination) uses `di_val` with the extra segment (index 3) and ignores the override.
- R9: Mode 0 (direct) offset is `disp_val` whatever `disp_en` is. Mode 1 (register indirect) offset is `base_val`.
- R10: Mode 2 (based) offset is `base_val` + d and mode 3 (indexed) offset is `index_val` + d. Here d is `disp_val` when `disp_en`=1 and 0 otherwise.
- R11: Mode 4 (based and indexed) offset is `base_val` + `index_val` + d, wrapping mod 2^16.
- R12: When `seg_we`=1, the register indexed by `seg_wsel` takes `seg_wdata` at the edge. A request in the same cycle still uses the value from before the write.
- R13: Access class codes 5 to 7 behave as class 2 (operand). Mode codes 5 to 7 behave as mode 0 (direct).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | Value written to the segment register |
| req | input | 1 | Address request strobe |
| acc_cls | input | 3 | Access class (0 fetch, 1 stack, 2 operand, 3 string source, 4 string destination) |
| ea_mode | input | 3 | Operand addressing mode (0 direct, 1 register indirect, 2 based, 3 indexed, 4 based and indexed) |
| use_bp | input | 1 | Stack: offset from BP; operand: base register is BP |
| disp_en | input | 1 | Displacement present in based/indexed modes |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment index |
| ip_val | input | 16 | Instruction pointer value |
| sp_val | input | 16 | Stack pointer value |
| bp_val | input | 16 | Frame base pointer value (stack class) |
| si_val | input | 16 | String source index value |
| di_val | input | 16 | String destination index value |
| base_val | input | 16 | Base register value for operand modes |
| index_val | input | 16 | Index register value for operand modes |
| disp_val | input | 16 | Instruction displacement |
| phys_addr | output | 20 | Registered physical address |
| addr_vld | output | 1 | Registered valid strobe for phys_addr |

## Verification
The bench sweeps every access class code, every mode code, both override states with all four override targets, both `use_bp` values and both `disp_en` values against three register sets. The first set has distinct, small segment values, so each wrong segment choice or wrong offset term gives a different address. The second set makes base + index + displacement overflow 16 bits, which separates a wrapped offset from an unwrapped one. The third set puts segments near 0xFFFF so that the 20-bit sum overflows, and this exposes a missing final wrap. Separate sequences test the same-cycle write against a request, a held output when no request is made, and a reset in the middle of the run.

// File: rtl/seg_addr_pkg.sv
// Package: shared codes for the segmented address generator.
// Assumes four segment registers; the index encoding below is used by the
// write port, the override selector and the internal segment choice.
package seg_addr_pkg;

    localparam int SEG_COUNT = 4;

    localparam logic [1:0] SEG_CODE  = 2'd0;
    localparam logic [1:0] SEG_DATA  = 2'd1;
    localparam logic [1:0] SEG_STACK = 2'd2;
    localparam logic [1:0] SEG_EXTRA = 2'd3;

    typedef enum logic [2:0] {
        ACC_FETCH = 3'd0,
        ACC_STACK = 3'd1,
        ACC_OPND  = 3'd2,
        ACC_SRC   = 3'd3,
        ACC_DST   = 3'd4
    } acc_e;

    typedef enum logic [2:0] {
        EA_DIRECT  = 3'd0,
        EA_REGIND  = 3'd1,
        EA_BASED   = 3'd2,
        EA_INDEXED = 3'd3,
        EA_BIDX    = 3'd4
    } ea_e;

endpackage

// File: rtl/seg_bank.sv
// Module: seg_bank
// Holds the segment registers with one write port and one read port.
// Assumes a synchronous active-low reset that clears every register; the
// read port shows the value before any write in the same cycle.
module seg_bank #(
    parameter int SEG_W = 16,
    parameter int NSEG  = 4,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [SEG_W-1:0] wdata,
    input  logic [SEL_W-1:0] rsel,
    output logic [SEG_W-1:0] rdata
);

    logic [SEG_W-1:0] regs [NSEG];

    generate
        for (genvar g = 0; g < NSEG; g++) begin : g_seg
            // Update one segment register on reset or a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (we && (wsel == SEL_W'(g))) begin
                    regs[g] <= wdata;
                end
            end
        end
    endgenerate

    // Read the selected register.
    always_comb begin
        rdata = regs[rsel];
    end

endmodule

// File: rtl/seg_pick.sv
// Module: seg_pick
// Chooses which segment register serves an access. Fetch, stack and string
// destination classes have fixed segments. Operand and string source
// classes take the override when present. An operand whose base register
// is BP defaults to the stack segment. Unknown class codes act as operand
// and unknown mode codes act as direct (no base register).
module seg_pick
    import seg_addr_pkg::*;
(
    input  logic [2:0] acc_cls,
    input  logic [2:0] ea_mode,
    input  logic       use_bp,
    input  logic       ovr_en,
    input  logic [1:0] ovr_sel,
    output logic [1:0] seg_sel
);

    logic has_base;

    // Flag the operand modes that include a base register.
    always_comb begin
        unique case (ea_e'(ea_mode))
            EA_REGIND, EA_BASED, EA_BIDX: has_base = 1'b1;
            default:                      has_base = 1'b0;
        endcase
    end

    // Map the access class to a segment index.
    always_comb begin
        unique case (acc_e'(acc_cls))
            ACC_FETCH: seg_sel = SEG_CODE;
            ACC_STACK: seg_sel = SEG_STACK;
            ACC_DST:   seg_sel = SEG_EXTRA;
            ACC_SRC:   seg_sel = ovr_en ? ovr_sel : SEG_DATA;
            default: begin
                if (ovr_en) begin
                    seg_sel = ovr_sel;
                end else if (use_bp && has_base) begin
                    seg_sel = SEG_STACK;
                end else begin
                    seg_sel = SEG_DATA;
                end
            end
        endcase
    end

endmodule

// File: rtl/ea_offset.sv
// Module: ea_offset
// Forms the effective offset for an access. Fetch, stack and string classes
// take a single pointer. Operand classes sum base, index and displacement
// as the mode dictates. All sums wrap at OFF_W bits. Unknown class codes
// act as operand and unknown mode codes act as direct.
module ea_offset
    import seg_addr_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic [2:0]       acc_cls,
    input  logic [2:0]       ea_mode,
    input  logic             use_bp,
    input  logic             disp_en,
    input  logic [OFF_W-1:0] ip_val,
    input  logic [OFF_W-1:0] sp_val,
    input  logic [OFF_W-1:0] bp_val,
    input  logic [OFF_W-1:0] si_val,
    input  logic [OFF_W-1:0] di_val,
    input  logic [OFF_W-1:0] base_val,
    input  logic [OFF_W-1:0] index_val,
    input  logic [OFF_W-1:0] disp_val,
    output logic [OFF_W-1:0] offset
);

    logic [OFF_W-1:0] disp_opt;
    logic [OFF_W-1:0] opnd_off;

    // Gate the optional displacement.
    always_comb begin
        disp_opt = disp_en ? disp_val : '0;
    end

    // Compose the operand offset from the addressing mode.
    always_comb begin
        unique case (ea_e'(ea_mode))
            EA_REGIND:  opnd_off = base_val;
            EA_BASED:   opnd_off = base_val + disp_opt;
            EA_INDEXED: opnd_off = index_val + disp_opt;
            EA_BIDX:    opnd_off = base_val + index_val + disp_opt;
            default:    opnd_off = disp_val;
        endcase
    end

    // Pick the offset source for the access class.
    always_comb begin
        unique case (acc_e'(acc_cls))
            ACC_FETCH: offset = ip_val;
            ACC_STACK: offset = use_bp ? bp_val : sp_val;
            ACC_SRC:   offset = si_val;
            ACC_DST:   offset = di_val;
            default:   offset = opnd_off;
        endcase
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Segmented physical address generator: picks a segment register from the
// access class, composes the effective offset, and registers
// (segment << SHIFT) + offset, wrapped to ADDR_W bits, one clock after req.
// Assumes OFF_W <= SEG_W + SHIFT and a synchronous active-low reset.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int SEL_W  = $clog2(SEG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_we,
    input  logic [SEL_W-1:0]  seg_wsel,
    input  logic [SEG_W-1:0]  seg_wdata,
    input  logic              req,
    input  logic [2:0]        acc_cls,
    input  logic [2:0]        ea_mode,
    input  logic              use_bp,
    input  logic              disp_en,
    input  logic              ovr_en,
    input  logic [SEL_W-1:0]  ovr_sel,
    input  logic [OFF_W-1:0]  ip_val,
    input  logic [OFF_W-1:0]  sp_val,
    input  logic [OFF_W-1:0]  bp_val,
    input  logic [OFF_W-1:0]  si_val,
    input  logic [OFF_W-1:0]  di_val,
    input  logic [OFF_W-1:0]  base_val,
    input  logic [OFF_W-1:0]  index_val,
    input  logic [OFF_W-1:0]  disp_val,
    output logic [ADDR_W-1:0] phys_addr,
    output logic              addr_vld
);

    logic [SEL_W-1:0]  seg_sel;
    logic [SEG_W-1:0]  seg_val;
    logic [OFF_W-1:0]  eff_off;
    logic [ADDR_W-1:0] sum_nxt;

    seg_bank #(
        .SEG_W (SEG_W),
        .NSEG  (SEG_COUNT)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (seg_we),
        .wsel  (seg_wsel),
        .wdata (seg_wdata),
        .rsel  (seg_sel),
        .rdata (seg_val)
    );

    seg_pick u_pick (
        .acc_cls (acc_cls),
        .ea_mode (ea_mode),
        .use_bp  (use_bp),
        .ovr_en  (ovr_en),
        .ovr_sel (ovr_sel),
        .seg_sel (seg_sel)
    );

    ea_offset #(
        .OFF_W (OFF_W)
    ) u_off (
        .acc_cls   (acc_cls),
        .ea_mode   (ea_mode),
        .use_bp    (use_bp),
        .disp_en   (disp_en),
        .ip_val    (ip_val),
        .sp_val    (sp_val),
        .bp_val    (bp_val),
        .si_val    (si_val),
        .di_val    (di_val),
        .base_val  (base_val),
        .index_val (index_val),
        .disp_val  (disp_val),
        .offset    (eff_off)
    );

    // Add the shifted segment to the zero-extended offset, wrapping at ADDR_W.
    always_comb begin
        sum_nxt = {seg_val, {SHIFT{1'b0}}} + {{(ADDR_W-OFF_W){1'b0}}, eff_off};
    end

    // Register the address and strobe on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr <= '0;
            addr_vld  <= 1'b0;
        end else begin
            addr_vld <= req;
            if (req) begin
                phys_addr <= sum_nxt;
            end
        end
    end

endmodule

// File: rtl/seg_addr_chk.sv
// Module: seg_addr_chk
// Checker bound to seg_addr_gen. Keeps its own shadow of the segment
// registers from the write port and checks timing and fixed-segment classes.
module seg_addr_chk #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seg_we,
    input logic [1:0]        seg_wsel,
    input logic [SEG_W-1:0]  seg_wdata,
    input logic              req,
    input logic [2:0]        acc_cls,
    input logic [2:0]        ea_mode,
    input logic              use_bp,
    input logic              ovr_en,
    input logic [OFF_W-1:0]  ip_val,
    input logic [OFF_W-1:0]  sp_val,
    input logic [OFF_W-1:0]  bp_val,
    input logic [OFF_W-1:0]  di_val,
    input logic [OFF_W-1:0]  disp_val,
    input logic [ADDR_W-1:0] phys_addr,
    input logic              addr_vld
);

    logic [SEG_W-1:0] sh_cs, sh_ds, sh_ss, sh_es;

    function automatic logic [ADDR_W-1:0] mk(input logic [SEG_W-1:0] s,
                                             input logic [OFF_W-1:0] o);
        return {s, {SHIFT{1'b0}}} + {{(ADDR_W-OFF_W){1'b0}}, o};
    endfunction

    // Shadow the segment registers from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cs <= '0; sh_ds <= '0; sh_ss <= '0; sh_es <= '0;
        end else if (seg_we) begin
            case (seg_wsel)
                2'd0:    sh_cs <= seg_wdata;
                2'd1:    sh_ds <= seg_wdata;
                2'd2:    sh_ss <= seg_wdata;
                default: sh_es <= seg_wdata;
            endcase
        end
    end

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> addr_vld); // R2
    AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !addr_vld); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(phys_addr)); // R2
    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && acc_cls == 3'd0) |=> phys_addr == mk($past(sh_cs), $past(ip_val))); // R4
    AST_STACK_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req && acc_cls == 3'd1) |=> phys_addr ==
            mk($past(sh_ss), $past(use_bp) ? $past(bp_val) : $past(sp_val))); // R5
    AST_DST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (req && acc_cls == 3'd4) |=> phys_addr == mk($past(sh_es), $past(di_val))); // R8
    AST_DIRECT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (req && acc_cls == 3'd2 && ea_mode == 3'd0 && !ovr_en) |=>
            phys_addr == mk($past(sh_ds), $past(disp_val))); // R6

endmodule

bind seg_addr_gen seg_addr_chk #(
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .SHIFT (SHIFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_we    (seg_we),
    .seg_wsel  (seg_wsel),
    .seg_wdata (seg_wdata),
    .req       (req),
    .acc_cls   (acc_cls),
    .ea_mode   (ea_mode),
    .use_bp    (use_bp),
    .ovr_en    (ovr_en),
    .ip_val    (ip_val),
    .sp_val    (sp_val),
    .bp_val    (bp_val),
    .di_val    (di_val),
    .disp_val  (disp_val),
    .phys_addr (phys_addr),
    .addr_vld  (addr_vld)
);

// File: tb/tb_seg_addr_gen.sv
`timescale 1ns/1ps
// Bench: sweeps access classes, modes, overrides and flags over three
// register sets, plus reset, hold and same-cycle write sequences.
module tb_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [1:0]  seg_wsel = '0;
    logic [15:0] seg_wdata = '0;
    logic        req = 1'b0;
    logic [2:0]  acc_cls = '0;
    logic [2:0]  ea_mode = '0;
    logic        use_bp = 1'b0;
    logic        disp_en = 1'b0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] ip_val = '0, sp_val = '0, bp_val = '0, si_val = '0;
    logic [15:0] di_val = '0, base_val = '0, index_val = '0, disp_val = '0;
    logic [19:0] phys_addr;
    logic        addr_vld;

    int total = 0;
    int bad = 0;
    logic [15:0] seg_m [4];

    always #2.5 clk = ~clk;

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_wsel(seg_wsel),
        .seg_wdata(seg_wdata), .req(req), .acc_cls(acc_cls), .ea_mode(ea_mode),
        .use_bp(use_bp), .disp_en(disp_en), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .ip_val(ip_val), .sp_val(sp_val), .bp_val(bp_val), .si_val(si_val),
        .di_val(di_val), .base_val(base_val), .index_val(index_val),
        .disp_val(disp_val), .phys_addr(phys_addr), .addr_vld(addr_vld)
    );

    task automatic check(input string req_tag, input logic [19:0] act,
                         input logic [19:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%05h expected=%05h", req_tag, act, exp);
        end
    endtask

    // Expected segment index from the requirements (R4-R8, R13).
    function automatic logic [1:0] exp_seg(input int c, input int m,
                                           input logic bp, input logic oe,
                                           input logic [1:0] os);
        if (c == 0) return 2'd0;
        if (c == 1) return 2'd2;
        if (c == 4) return 2'd3;
        if (oe) return os;
        if (c == 3) return 2'd1;
        if (bp && (m == 1 || m == 2 || m == 4)) return 2'd2;
        return 2'd1;
    endfunction

    // Expected offset from the requirements (R4, R5, R8-R11, R13).
    function automatic logic [15:0] exp_off(input int c, input int m,
                                            input logic bp, input logic de);
        logic [15:0] d;
        d = de ? disp_val : 16'h0;
        if (c == 0) return ip_val;
        if (c == 1) return bp ? bp_val : sp_val;
        if (c == 3) return si_val;
        if (c == 4) return di_val;
        case (m)
            1: return base_val;
            2: return base_val + d;
            3: return index_val + d;
            4: return base_val + index_val + d;
            default: return disp_val;
        endcase
    endfunction

    function automatic string tag(input int c, input int m, input logic bp,
                                  input logic oe);
        if (c == 0) return "R4";
        if (c == 1) return "R5";
        if (c == 3 || c == 4) return "R8";
        if (c > 4 || m > 4) return "R13";
        if (oe) return "R6";
        if (bp && (m == 1 || m == 2 || m == 4)) return "R7";
        if (m < 2) return "R9";
        if (m < 4) return "R10";
        return "R11";
    endfunction

    // Write a segment register through the port (R12 path).
    task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
        seg_we = 1'b1; seg_wsel = s; seg_wdata = v;
        @(negedge clk);
        seg_we = 1'b0;
        seg_m[s] = v;
    endtask

    task automatic sweep(input string extra);
        for (int c = 0; c < 8; c++) begin
            for (int m = 0; m < 8; m++) begin
                for (int o = 0; o < 8; o++) begin
                    for (int f = 0; f < 4; f++) begin
                        logic [19:0] e;
                        req = 1'b1; acc_cls = 3'(c); ea_mode = 3'(m);
                        ovr_en = o[2]; ovr_sel = o[1:0];
                        use_bp = f[0]; disp_en = f[1];
                        e = {seg_m[exp_seg(c, m, f[0], o[2], o[1:0])], 4'h0}
                            + {4'h0, exp_off(c, m, f[0], f[1])};
                        @(negedge clk);
                        check({tag(c, m, f[0], o[2]), extra}, phys_addr, e);
                    end
                end
            end
        end
        req = 1'b0;
    endtask

    task automatic load_set(input logic [15:0] s0, s1, s2, s3,
                            input logic [15:0] ip, sp, bp, si, di, b, x, d);
        wr_seg(2'd0, s0); wr_seg(2'd1, s1); wr_seg(2'd2, s2); wr_seg(2'd3, s3);
        ip_val = ip; sp_val = sp; bp_val = bp; si_val = si; di_val = di;
        base_val = b; index_val = x; disp_val = d;
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [19:0] held;
        for (int i = 0; i < 4; i++) seg_m[i] = 16'h0;
        repeat (3) @(negedge clk);
        check("R1 vld", {19'h0, addr_vld}, 20'h0);
        check("R1 addr", phys_addr, 20'h0);
        rst_n = 1'b1;
        // R1: segments clear, fetch gives offset alone
        req = 1'b1; acc_cls = 3'd0; ip_val = 16'hBEEF;
        @(negedge clk);
        check("R1 seg zero", phys_addr, 20'h0BEEF);
        check("R2 vld", {19'h0, addr_vld}, 20'h1);
        req = 1'b0;

        // Set 0: distinct small values
        load_set(16'h1234, 16'h2345, 16'h3456, 16'h4567, 16'h0100, 16'hFFF0,
                 16'h0200, 16'h0300, 16'h0400, 16'h1000, 16'h0020, 16'h0005);
        sweep("");
        // Set 1: 16-bit offset wrap
        load_set(16'h0000, 16'hFFFF, 16'h8000, 16'h0001, 16'hFFFF, 16'h0001,
                 16'h7FFF, 16'hABCD, 16'h0000, 16'hF000, 16'h1800, 16'h0900);
        sweep("/R3 off wrap");
        // Set 2: 20-bit sum wrap
        load_set(16'hFFFF, 16'hFFFE, 16'hF000, 16'hFFF0, 16'hFFFF, 16'hFFFF,
                 16'h8000, 16'h0FFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        sweep("/R3 addr wrap");

        // R2: no request holds the address and drops valid
        req = 1'b1; acc_cls = 3'd0; ip_val = 16'h0042;
        @(negedge clk);
        held = phys_addr;
        req = 1'b0; ip_val = 16'h1111;
        @(negedge clk);
        check("R2 idle vld", {19'h0, addr_vld}, 20'h0);
        check("R2 hold", phys_addr, held);
        @(negedge clk);
        check("R2 hold2", phys_addr, held);

        // R12: write and request in the same cycle use the old value
        wr_seg(2'd0, 16'h1234);
        req = 1'b1; acc_cls = 3'd0; ip_val = 16'h0010;
        seg_we = 1'b1; seg_wsel = 2'd0; seg_wdata = 16'h0ABC;
        @(negedge clk);
        seg_we = 1'b0;
        check("R12 old value", phys_addr, 20'h12350);
        @(negedge clk);
        check("R12 new value", phys_addr, 20'h0ABD0);
        req = 1'b0;

        // R1: reset in mid-run clears outputs and segments
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid vld", {19'h0, addr_vld}, 20'h0);
        check("R1 mid addr", phys_addr, 20'h0);
        rst_n = 1'b1;
        req = 1'b1; acc_cls = 3'd4; di_val = 16'h0777;
        @(negedge clk);
        check("R1 mid seg", phys_addr, 20'h00777);
        req = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule